// File: doc/BRIEF.md
# Program-Cycle Status Reporter

This block decides what a host sees on the read data bus while a nonvolatile program cycle runs. A separate write controller supplies a busy level and the byte it is programming. When the host reads during that busy period, the block does not return array data. It returns a status byte. The top bit of that byte is the complement of the top bit of the byte being written. The next bit flips once per finished read. All lower bits are zero. When busy drops, reads return array data unchanged again.

A ready line runs alongside the data bus. It is modelled as an open-drain driver: a constant-zero data bit plus an enable. The enable is asserted for the whole busy period. An active-low protect input blocks reads: while it is low the data bus floats, and an access made under it does not count as a read. All outputs are registered, so they follow their inputs by one clock.

Top module: `wsr_status_top`

## Requirements
- R1: While `rst_n` is low, `dq_oe_o` and `rdy_oe_o` are 0 and `dq_o` is 0.
- R2: When `prot_n` is 1, `sel_n` and `rden_n` are both 0 and `busy_i` is 0 at a clock edge, then after that edge `dq_oe_o` is 1 and `dq_o` equals `arr_data_i`.
- R3: During a read with `busy_i` at 1, `dq_o[7]` is the complement of `last_wr_i[7]`.
- R4: The first read in a busy period returns `dq_o[6]` = 1.
- R5: While busy, `dq_o[6]` changes value after each completed read. A read is completed on the first edge where `sel_n` or `rden_n` is 1 again after a read edge, with `prot_n` at 1.
- R6: A new busy period sets the toggle bit back to 1 on the edge where `busy_i` is first seen high, whatever value it held before.
- R7: During a read with `busy_i` at 1, `dq_o[5:0]` is 0 and array data is not visible.
- R8: While `prot_n` is 0, `dq_oe_o` is 0 after the edge. An access held under `prot_n` = 0 does not advance the toggle bit.
- R9: `rdy_oe_o` equals `busy_i` from the previous edge, and `rdy_o` is always 0.
- R10: Whenever `dq_oe_o` is 0, `dq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prot_n | input | 1 | Active-low read protect; low floats the bus |
| busy_i | input | 1 | Program cycle in progress, from the write controller |
| last_wr_i | input | 8 | Byte currently being programmed |
| sel_n | input | 1 | Active-low chip select |
| rden_n | input | 1 | Active-low output enable |
| arr_data_i | input | 8 | Array read data |
| dq_o | output | 8 | Read data bus value |
| dq_oe_o | output | 1 | Read data bus drive enable |
| rdy_oe_o | output | 1 | Ready line pull-down enable |
| rdy_o | output | 1 | Ready line data, constant 0 |

## Verification
The hardest case to reach is a toggle bit that is already 0 when a new busy period starts, because R6 can only be seen if the reset actually changes the value. The stimulus gets there in two steps. First it makes an odd number of completed reads in one busy period. Then it ends that period with the toggle at 0, starts another, and checks that the first read returns 1. A read held open while protect is low is handled in a similar way. The stimulus releases that read only after protect returns, then checks that the next read shows the toggle value unchanged.

// File: rtl/wsr_pkg.sv
package wsr_pkg;
    localparam int WSR_DW = 8;

    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_ARRAY  = 2'd1,
        SRC_STATUS = 2'd2
    } src_e;
endpackage

// File: rtl/wsr_strobe.sv
module wsr_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic prot_n,
    input  logic sel_n,
    input  logic rden_n,
    input  logic busy_i,
    output logic rd_now,
    output logic rd_done,
    output logic busy_start
);
    typedef struct packed {
        logic rd;
        logic busy;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        rd_now     = prot_n & ~sel_n & ~rden_n;
        rd_done    = st_q.rd & ~rd_now & prot_n;
        busy_start = busy_i & ~st_q.busy;
        st_d       = st_q;
        st_d.rd    = rd_now;
        st_d.busy  = busy_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_no_done_under_prot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !prot_n |-> !rd_done);
endmodule

// File: rtl/wsr_toggle.sv
module wsr_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic busy_i,
    input  logic busy_start,
    input  logic rd_done,
    output logic tog_o
);
    typedef struct packed {
        logic tog;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (busy_start)
            st_d.tog = 1'b1;
        else if (busy_i && rd_done)
            st_d.tog = ~st_q.tog;
        tog_o = st_q.tog;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{tog: 1'b1};
        else        st_q <= st_d;
    end

    assert_toggle_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_start |=> tog_o);
    assert_toggle_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && rd_done && !busy_start) |=> (tog_o != $past(tog_o)));
endmodule

// File: rtl/wsr_outmux.sv
module wsr_outmux
    import wsr_pkg::*;
#(
    parameter int DW = WSR_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  src_e          src,
    input  logic [DW-1:0] last_wr,
    input  logic [DW-1:0] arr_data,
    input  logic          tog,
    output logic [DW-1:0] dq_o,
    output logic          dq_oe_o
);
    localparam int POLL_BIT = DW - 1;
    localparam int TOG_BIT  = DW - 2;

    typedef struct packed {
        logic          oe;
        logic [DW-1:0] dq;
    } st_t;

    st_t st_d, st_q;
    logic unused_low_bits;

    assign unused_low_bits = ^last_wr[DW-2:0];

    always_comb begin
        st_d = '0;
        case (src)
            SRC_ARRAY: begin
                st_d.oe = 1'b1;
                st_d.dq = arr_data;
            end
            SRC_STATUS: begin
                st_d.oe           = 1'b1;
                st_d.dq[POLL_BIT] = ~last_wr[POLL_BIT];
                st_d.dq[TOG_BIT]  = tog;
            end
            default: st_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dq_o    = st_q.dq;
    assign dq_oe_o = st_q.oe;

    assert_quiet_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_oe_o |-> (dq_o == '0));
    assert_status_low_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_STATUS) |=> (dq_o[DW-3:0] == '0));
endmodule

// File: rtl/wsr_status_top.sv
module wsr_status_top
    import wsr_pkg::*;
#(
    parameter int DW = WSR_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prot_n,
    input  logic          busy_i,
    input  logic [DW-1:0] last_wr_i,
    input  logic          sel_n,
    input  logic          rden_n,
    input  logic [DW-1:0] arr_data_i,
    output logic [DW-1:0] dq_o,
    output logic          dq_oe_o,
    output logic          rdy_oe_o,
    output logic          rdy_o
);
    typedef struct packed {
        logic rdy_oe;
    } st_t;

    st_t  st_d, st_q;
    logic rd_now, rd_done, busy_start, tog;
    src_e src;

    wsr_strobe u_strobe (
        .clk        (clk),
        .rst_n      (rst_n),
        .prot_n     (prot_n),
        .sel_n      (sel_n),
        .rden_n     (rden_n),
        .busy_i     (busy_i),
        .rd_now     (rd_now),
        .rd_done    (rd_done),
        .busy_start (busy_start)
    );

    wsr_toggle u_toggle (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy_i     (busy_i),
        .busy_start (busy_start),
        .rd_done    (rd_done),
        .tog_o      (tog)
    );

    always_comb begin
        if (!rd_now)     src = SRC_NONE;
        else if (busy_i) src = SRC_STATUS;
        else             src = SRC_ARRAY;
        st_d        = st_q;
        st_d.rdy_oe = busy_i;
    end

    wsr_outmux #(.DW(DW)) u_outmux (
        .clk      (clk),
        .rst_n    (rst_n),
        .src      (src),
        .last_wr  (last_wr_i),
        .arr_data (arr_data_i),
        .tog      (tog),
        .dq_o     (dq_o),
        .dq_oe_o  (dq_oe_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdy_oe_o = st_q.rdy_oe;
    assign rdy_o    = 1'b0;

    assert_rdy_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> rdy_oe_o);
    assert_rdy_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_i |=> !rdy_oe_o);
    assert_float_prot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !prot_n |=> !dq_oe_o);
    assert_poll_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_now && busy_i) |=> (dq_o[DW-1] == ~$past(last_wr_i[DW-1])));
    assert_array_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_now && !busy_i) |=> (dq_oe_o && dq_o == $past(arr_data_i)));
endmodule

// File: tb/tb_wsr_status_top.sv
`timescale 1ns/1ps
module tb_wsr_status_top;
    logic       clk = 1'b0;
    logic       rst_n, prot_n, busy_i, sel_n, rden_n;
    logic [7:0] last_wr_i, arr_data_i, dq_o;
    logic       dq_oe_o, rdy_oe_o, rdy_o;
    int         n_chk = 0;
    int         n_bad = 0;

    always #2 clk = ~clk;

    wsr_status_top dut (
        .clk(clk), .rst_n(rst_n), .prot_n(prot_n), .busy_i(busy_i),
        .last_wr_i(last_wr_i), .sel_n(sel_n), .rden_n(rden_n),
        .arr_data_i(arr_data_i), .dq_o(dq_o), .dq_oe_o(dq_oe_o),
        .rdy_oe_o(rdy_oe_o), .rdy_o(rdy_o)
    );

    // {prot_n,busy,sel_n,rden_n} last arr | exp_oe exp_dq exp_rdy
    localparam int NV = 18;
    localparam logic [29:0] VEC [0:NV-1] = '{
        {4'b1011, 8'h00, 8'h00, 1'b0, 8'h00, 1'b0}, // idle
        {4'b1000, 8'h00, 8'h5A, 1'b1, 8'h5A, 1'b0}, // R2 array read
        {4'b1011, 8'h00, 8'h5A, 1'b0, 8'h00, 1'b0}, // release
        {4'b1111, 8'h83, 8'hFF, 1'b0, 8'h00, 1'b1}, // R9 busy begins
        {4'b1100, 8'h83, 8'hFF, 1'b1, 8'h40, 1'b1}, // R3 R4 R7 first read
        {4'b1111, 8'h83, 8'hFF, 1'b0, 8'h00, 1'b1}, // R5 release
        {4'b1100, 8'h83, 8'hFF, 1'b1, 8'h00, 1'b1}, // R5 toggle now 0
        {4'b1111, 8'h05, 8'hFF, 1'b0, 8'h00, 1'b1}, // release
        {4'b1100, 8'h05, 8'hFF, 1'b1, 8'hC0, 1'b1}, // R3 bit7 low -> 1
        {4'b1111, 8'h05, 8'hFF, 1'b0, 8'h00, 1'b1}, // release, tog 0
        {4'b1000, 8'h05, 8'h3C, 1'b1, 8'h3C, 1'b0}, // R2 R9 busy over
        {4'b1011, 8'h05, 8'h3C, 1'b0, 8'h00, 1'b0}, // R10 idle
        {4'b1111, 8'h80, 8'hAA, 1'b0, 8'h00, 1'b1}, // R6 new busy
        {4'b1100, 8'h80, 8'hAA, 1'b1, 8'h40, 1'b1}, // R6 tog back to 1
        {4'b0100, 8'h80, 8'hAA, 1'b0, 8'h00, 1'b1}, // R8 protect floats
        {4'b1111, 8'h80, 8'hAA, 1'b0, 8'h00, 1'b1}, // release after protect
        {4'b1100, 8'h80, 8'hAA, 1'b1, 8'h40, 1'b1}, // R8 no toggle advance
        {4'b1011, 8'h80, 8'hAA, 1'b0, 8'h00, 1'b0}  // R9 ready released
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        for (int i = 0; i < 200000; i++) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; prot_n = 1'b1; busy_i = 1'b0; sel_n = 1'b1; rden_n = 1'b1;
        last_wr_i = 8'h00; arr_data_i = 8'h00;
        repeat (3) @(negedge clk);
        check("R1 dq_oe", {7'd0, dq_oe_o}, 8'h00);
        check("R1 rdy_oe", {7'd0, rdy_oe_o}, 8'h00);
        check("R1 dq", dq_o, 8'h00);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            {prot_n, busy_i, sel_n, rden_n} = VEC[i][29:26];
            last_wr_i  = VEC[i][25:18];
            arr_data_i = VEC[i][17:10];
            @(posedge clk);
            @(negedge clk);
            check($sformatf("R2-vector %0d oe", i), {7'd0, dq_oe_o}, {7'd0, VEC[i][9]});
            check($sformatf("R3/R7 vector %0d dq", i), dq_o, VEC[i][8:1]);
            check($sformatf("R9 vector %0d rdy", i), {7'd0, rdy_oe_o}, {7'd0, VEC[i][0]});
        end

        // R9: ready data bit stays 0
        check("R9 rdy data", {7'd0, rdy_o}, 8'h00);

        // R1: reset in the middle of a busy read clears the outputs at once
        busy_i = 1'b1; sel_n = 1'b0; rden_n = 1'b0; last_wr_i = 8'h00;
        @(posedge clk); @(negedge clk);
        check("R4 read after restart", dq_o, 8'hC0);
        rst_n = 1'b0;
        #1;
        check("R1 mid-cycle oe", {7'd0, dq_oe_o}, 8'h00);
        check("R1 mid-cycle rdy", {7'd0, rdy_oe_o}, 8'h00);
        @(negedge clk);
        busy_i = 1'b0; sel_n = 1'b1; rden_n = 1'b1;
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R10 idle dq", dq_o, 8'h00);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule